// File: doc/BRIEF.md
# Transponder Write Command Controller

This block sits behind the field-gap decoder of a contactless memory tag. While the reader writes, the decoder hands it one recovered bit at a time with a valid strobe, and then an end-of-frame strobe. The controller parses the frame and checks its length, the optional inline password and the write protection of the target block. When every check passes it issues exactly one program request for a 33-bit memory word. A stop command raises a one-cycle stop flag. Every rejected frame raises a one-cycle error flag instead.

The memory has eight 33-bit blocks. Bit 0 of each block is a lock bit, and a locked block can never be written again, lock bit included. When password mode is on, the frame carries 32 password bits. These are compared with the password stored in block 7, which the surrounding logic presents on `pwd_word`.

The state machine has four states:
- `ST_IDLE`: waits for the first bit.
- `ST_OPCODE`: holds the first opcode bit.
- `ST_BODY`: collects the payload after a standard opcode.
- `ST_DRAIN`: discards the rest of a stopped or bad frame.

Its transitions are:
- `ST_IDLE` to `ST_OPCODE` on a bit.
- `ST_OPCODE` to `ST_BODY` on opcode 10.
- `ST_OPCODE` to `ST_DRAIN` on any other second bit.
- `ST_OPCODE` to `ST_IDLE` on an early end-of-frame, with an error.
- `ST_BODY` and `ST_DRAIN` to `ST_IDLE` on end-of-frame.

Top module: `wrcmd_ctrl`

## Requirements
- R1: The first two bits of a frame form the opcode. Binary 10 (first bit 1, second bit 0) is a standard write, and binary 11 is stop.
- R2: Opcodes 00 and 01 raise `err_flag` for one cycle, in the cycle after the second bit is strobed. The remaining bits of that frame are discarded, and its end-of-frame strobe produces no further output.
- R3: The stop opcode raises `stop_flag` for one cycle, in the cycle after the second bit is strobed. It never raises `prog_req`, and the rest of its frame is discarded.
- R4: After a standard opcode, the frame carries the fields below, with multi-bit fields sent MSB first:
  - 32 password bits, present only in password mode;
  - one lock bit;
  - 32 data bits;
  - a 3-bit block address.

  `prog_word` bit 0 is the lock bit, and bits 32:1 are the data.
- R5: The number of bits after the opcode must be exactly 36 without password mode, or 68 with it. Any other count raises `err_flag` and suppresses `prog_req`.
- R6: In password mode, if the received password differs from `pwd_word`, the frame raises `err_flag` and no program request is issued.
- R7: If bit `a` of `blk_locks` is set, a write to block `a` raises `err_flag`, issues no program request, and leaves `prog_addr`/`prog_word` unchanged.
- R8: A valid standard frame raises `prog_req` for one cycle, in the cycle after the end-of-frame strobe, with `prog_addr` and `prog_word` set. Both fields hold their value until the next request.
- R9: At most one of `prog_req`, `stop_flag` and `err_flag` is high in any cycle, and each frame yields at most one of them.
- R10: After reset all outputs are 0. An end-of-frame strobe that arrives with no bits received produces no output.
- R11: An end-of-frame strobe after only one opcode bit raises `err_flag`.
- R12: The password mode is sampled when the standard opcode completes. A change of `pwd_mode` later in the frame does not alter that frame's layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_vld | input | 1 | Strobe: `bit_val` carries a received bit |
| bit_val | input | 1 | Received bit value |
| frame_end | input | 1 | Strobe: the current frame has ended |
| pwd_mode | input | 1 | Password mode enable |
| pwd_word | input | 32 | Stored password (block 7 contents) |
| blk_locks | input | 8 | Lock bit of each block, bit a for block a |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | 3 | Block to program |
| prog_word | output | 33 | Word to program, lock bit in bit 0 |
| stop_flag | output | 1 | One-cycle stop indication |
| err_flag | output | 1 | One-cycle frame rejection |

## Verification
The embedded properties assume the following about the inputs:
- `bit_vld` and `frame_end` never fall in the same cycle;
- `pwd_word` and `blk_locks` are steady in the cycle in which end-of-frame is strobed.

The bench drives each bit on its own falling edge and gives the end-of-frame strobe a cycle of its own after the last bit. It changes the lock vector only between frames, with idle cycles in between, so every checked outcome arises from a single well-formed strobe sequence.

// File: rtl/wrcmd_pkg.sv
package wrcmd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_BODY,
        ST_DRAIN
    } wr_state_e;

    localparam logic [1:0] OP_WRITE = 2'b10;
    localparam logic [1:0] OP_STOP  = 2'b11;

endpackage

// File: rtl/wrcmd_collect.sv
module wrcmd_collect #(
    parameter int PWD_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int PAY_W  = 1 + DATA_W + ADDR_W,
    parameter int CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift_en,
    input  logic             bit_val,
    input  logic             pwd_on,
    output logic [CNT_W-1:0] cnt,
    output logic [PWD_W-1:0] pwd_rx,
    output logic [PAY_W-1:0] pay_rx
);

    logic in_pwd;

    // While password mode is active, the first PWD_W body bits belong to the password.
    assign in_pwd = pwd_on && (cnt < CNT_W'(PWD_W));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            pwd_rx <= '0;
            pay_rx <= '0;
        end else if (clr) begin
            cnt    <= '0;
            pwd_rx <= '0;
            pay_rx <= '0;
        end else if (shift_en) begin
            if (cnt != '1) begin
                cnt <= cnt + 1'b1;
            end
            if (in_pwd) begin
                pwd_rx <= {pwd_rx[PWD_W-2:0], bit_val};
            end else begin
                pay_rx <= {pay_rx[PAY_W-2:0], bit_val};
            end
        end
    end

    // R5: a cleared counter starts the body count from zero
    a_r5_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

endmodule

// File: rtl/wrcmd_fsm.sv
module wrcmd_fsm
    import wrcmd_pkg::*;
#(
    parameter int PWD_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int PAY_W  = 1 + DATA_W + ADDR_W,
    parameter int CNT_W  = 8,
    parameter int NBLK   = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              bit_val,
    input  logic              frame_end,
    input  logic              pwd_mode,
    input  logic [PWD_W-1:0]  pwd_word,
    input  logic [NBLK-1:0]   blk_locks,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [PWD_W-1:0]  pwd_rx,
    input  logic [PAY_W-1:0]  pay_rx,
    output logic              clr,
    output logic              shift_en,
    output logic              pwd_on,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W:0]   prog_word,
    output logic              stop_flag,
    output logic              err_flag
);

    localparam logic [CNT_W-1:0] LEN_PLAIN = CNT_W'(PAY_W);
    localparam logic [CNT_W-1:0] LEN_PWD   = CNT_W'(PWD_W + PAY_W);

    wr_state_e         state_q, state_d;
    logic              op_hi_q;
    logic              pwd_on_q;
    logic [1:0]        op_code;
    logic              bit_in;
    logic              len_ok, pwd_ok, lock_ok, frame_good;
    logic [ADDR_W-1:0] tgt_addr;
    logic [DATA_W:0]   tgt_word;

    assign op_code    = {op_hi_q, bit_val};
    assign bit_in     = bit_vld && !frame_end;
    assign len_ok     = (cnt == (pwd_on_q ? LEN_PWD : LEN_PLAIN));
    assign pwd_ok     = !pwd_on_q || (pwd_rx == pwd_word);
    assign tgt_addr   = pay_rx[ADDR_W-1:0];
    assign tgt_word   = {pay_rx[PAY_W-2 -: DATA_W], pay_rx[PAY_W-1]};
    assign lock_ok    = !blk_locks[tgt_addr];
    assign frame_good = len_ok && pwd_ok && lock_ok;

    assign clr      = (state_q == ST_OPCODE) && bit_in && (op_code == OP_WRITE);
    assign shift_en = (state_q == ST_BODY) && bit_in;
    assign pwd_on   = pwd_on_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (bit_in) state_d = ST_OPCODE;
            end
            ST_OPCODE: begin
                if (frame_end)   state_d = ST_IDLE;
                else if (bit_vld) state_d = (op_code == OP_WRITE) ? ST_BODY : ST_DRAIN;
            end
            ST_BODY: begin
                if (frame_end) state_d = ST_IDLE;
            end
            ST_DRAIN: begin
                if (frame_end) state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output and context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_hi_q   <= 1'b0;
            pwd_on_q  <= 1'b0;
            prog_req  <= 1'b0;
            prog_addr <= '0;
            prog_word <= '0;
            stop_flag <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            prog_req  <= 1'b0;
            stop_flag <= 1'b0;
            err_flag  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (bit_in) op_hi_q <= bit_val;
                end
                ST_OPCODE: begin
                    if (frame_end) begin
                        err_flag <= 1'b1;
                    end else if (bit_vld) begin
                        if (op_code == OP_WRITE)     pwd_on_q  <= pwd_mode;
                        else if (op_code == OP_STOP) stop_flag <= 1'b1;
                        else                         err_flag  <= 1'b1;
                    end
                end
                ST_BODY: begin
                    if (frame_end) begin
                        if (frame_good) begin
                            prog_req  <= 1'b1;
                            prog_addr <= tgt_addr;
                            prog_word <= tgt_word;
                        end else begin
                            err_flag <= 1'b1;
                        end
                    end
                end
                ST_DRAIN: begin
                end
            endcase
        end
    end

    // R9: one outcome at a time
    a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_req, stop_flag, err_flag}));

    // R9: a program request lasts one cycle
    a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req);

    // R8: a request only follows an end-of-frame seen while collecting the body
    a_r8_req_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> ($past(frame_end) && ($past(state_q) == ST_BODY)));

    // R7: never program a block whose lock bit was set
    a_r7_no_locked_prog: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> ((($past(blk_locks) >> prog_addr) & NBLK'(1)) == NBLK'(0)));

    // R6: in password mode a request implies the collected password matched
    a_r6_pwd_matched: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && $past(pwd_on_q)) |-> $past(pwd_rx == pwd_word));

    // R3: stop only as a direct result of the second opcode bit
    a_r3_stop_from_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        stop_flag |-> ($past(state_q) == ST_OPCODE && $past(bit_vld)));

endmodule

// File: rtl/wrcmd_ctrl.sv
module wrcmd_ctrl #(
    parameter int PWD_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bit_vld,
    input  logic                     bit_val,
    input  logic                     frame_end,
    input  logic                     pwd_mode,
    input  logic [PWD_W-1:0]         pwd_word,
    input  logic [(1<<ADDR_W)-1:0]   blk_locks,
    output logic                     prog_req,
    output logic [ADDR_W-1:0]        prog_addr,
    output logic [DATA_W:0]          prog_word,
    output logic                     stop_flag,
    output logic                     err_flag
);

    localparam int NBLK  = 1 << ADDR_W;
    localparam int PAY_W = 1 + DATA_W + ADDR_W;
    localparam int CNT_W = $clog2(PWD_W + PAY_W + 1) + 1;

    logic             clr, shift_en, pwd_on;
    logic [CNT_W-1:0] cnt;
    logic [PWD_W-1:0] pwd_rx;
    logic [PAY_W-1:0] pay_rx;

    wrcmd_collect #(
        .PWD_W (PWD_W),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .PAY_W (PAY_W),
        .CNT_W (CNT_W)
    ) u_collect (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .shift_en(shift_en),
        .bit_val (bit_val),
        .pwd_on  (pwd_on),
        .cnt     (cnt),
        .pwd_rx  (pwd_rx),
        .pay_rx  (pay_rx)
    );

    wrcmd_fsm #(
        .PWD_W (PWD_W),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .PAY_W (PAY_W),
        .CNT_W (CNT_W),
        .NBLK  (NBLK)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld  (bit_vld),
        .bit_val  (bit_val),
        .frame_end(frame_end),
        .pwd_mode (pwd_mode),
        .pwd_word (pwd_word),
        .blk_locks(blk_locks),
        .cnt      (cnt),
        .pwd_rx   (pwd_rx),
        .pay_rx   (pay_rx),
        .clr      (clr),
        .shift_en (shift_en),
        .pwd_on   (pwd_on),
        .prog_req (prog_req),
        .prog_addr(prog_addr),
        .prog_word(prog_word),
        .stop_flag(stop_flag),
        .err_flag (err_flag)
    );

endmodule

// File: tb/wrcmd_ctrl_bench.sv
module wrcmd_ctrl_bench;

    localparam int K_PROG = 1;
    localparam int K_STOP = 2;
    localparam int K_ERR  = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bit_vld, bit_val, frame_end, pwd_mode;
    logic [31:0] pwd_word;
    logic [7:0]  blk_locks;
    logic        prog_req, stop_flag, err_flag;
    logic [2:0]  prog_addr;
    logic [32:0] prog_word;

    always #2 clk = ~clk;

    wrcmd_ctrl u_wrcmd_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld  (bit_vld),
        .bit_val  (bit_val),
        .frame_end(frame_end),
        .pwd_mode (pwd_mode),
        .pwd_word (pwd_word),
        .blk_locks(blk_locks),
        .prog_req (prog_req),
        .prog_addr(prog_addr),
        .prog_word(prog_word),
        .stop_flag(stop_flag),
        .err_flag (err_flag)
    );

    typedef struct {
        int          kind;
        logic [2:0]  addr;
        logic [32:0] word;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    bit   txq[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;

    task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic expect_item(int kind, logic [2:0] a, logic [32:0] w, string tag);
        exp_t e;
        e.kind = kind;
        e.addr = a;
        e.word = w;
        e.tag  = tag;
        sbq.push_back(e);
    endtask

    task automatic put(logic [31:0] v, int n);
        for (int i = n - 1; i >= 0; i--) txq.push_back(v[i]);
    endtask

    task automatic std_frame(bit use_pw, logic [31:0] pw, bit lk, logic [31:0] d, logic [2:0] a);
        put(32'b10, 2);
        if (use_pw) put(pw, 32);
        put({31'b0, lk}, 1);
        put(d, 32);
        put({29'b0, a}, 3);
    endtask

    task automatic send(int flip_at);
        for (int i = 0; i < txq.size(); i++) begin
            @(negedge clk);
            if (i == flip_at) pwd_mode = ~pwd_mode;
            bit_vld = 1'b1;
            bit_val = txq[i];
        end
        @(negedge clk);
        bit_vld   = 1'b0;
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        txq.delete();
        repeat (4) @(negedge clk);
    endtask

    // Monitor: pops the scoreboard whenever an outcome appears
    always @(negedge clk) begin
        exp_t e;
        int   k;
        if (rst_n && !done) begin
            if ((int'(prog_req) + int'(stop_flag) + int'(err_flag)) > 1)
                check(1'b0, "R9", "several outcomes at once",
                      {61'b0, prog_req, stop_flag, err_flag}, 0);
            k = prog_req ? K_PROG : (stop_flag ? K_STOP : (err_flag ? K_ERR : 0));
            if (k != 0) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R9", "unexpected outcome", k, 0);
                end else begin
                    e = sbq.pop_front();
                    check(k == e.kind, e.tag, "outcome kind", k, e.kind);
                    if (k == K_PROG && e.kind == K_PROG) begin
                        check(prog_addr == e.addr, e.tag, "prog_addr", prog_addr, e.addr);
                        check(prog_word == e.word, e.tag, "prog_word", prog_word, e.word);
                    end
                end
            end
        end
    end

    initial begin
        rst_n     = 1'b0;
        bit_vld   = 1'b0;
        bit_val   = 1'b0;
        frame_end = 1'b0;
        pwd_mode  = 1'b0;
        pwd_word  = 32'hC0DE_5EED;
        blk_locks = 8'h00;
        repeat (3) @(negedge clk);
        check({prog_req, stop_flag, err_flag} == 3'b0, "R10", "pulses in reset",
              {prog_req, stop_flag, err_flag}, 0);
        check(prog_word == '0 && prog_addr == '0, "R10", "fields in reset",
              prog_word, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4 R8: plain write, lock bit clear
        expect_item(K_PROG, 3'd3, {32'hA5A5_1234, 1'b0}, "R8");
        std_frame(0, 0, 1'b0, 32'hA5A5_1234, 3'd3);
        send(-1);

        // R4: lock bit set lands in word bit 0
        expect_item(K_PROG, 3'd5, {32'h0F0F_8001, 1'b1}, "R4");
        std_frame(0, 0, 1'b1, 32'h0F0F_8001, 3'd5);
        send(-1);

        // R7: locked target is refused and the request fields hold
        blk_locks = 8'b0010_0000;
        expect_item(K_ERR, 0, 0, "R7");
        std_frame(0, 0, 1'b0, 32'hFFFF_FFFF, 3'd5);
        send(-1);
        check(prog_addr == 3'd5, "R7", "addr held", prog_addr, 5);
        check(prog_word == {32'h0F0F_8001, 1'b1}, "R7", "word held",
              prog_word, {32'h0F0F_8001, 1'b1});

        // R1: writes to block 0 and block 7 while only block 5 is locked
        expect_item(K_PROG, 3'd0, {32'h1357_9BDF, 1'b0}, "R1");
        std_frame(0, 0, 1'b0, 32'h1357_9BDF, 3'd0);
        send(-1);
        expect_item(K_PROG, 3'd7, {32'h8000_0001, 1'b1}, "R1");
        std_frame(0, 0, 1'b1, 32'h8000_0001, 3'd7);
        send(-1);
        blk_locks = 8'h00;

        // R6: password mode, matching and wrong password
        pwd_mode = 1'b1;
        expect_item(K_PROG, 3'd2, {32'hDEAD_BEEF, 1'b0}, "R6");
        std_frame(1, 32'hC0DE_5EED, 1'b0, 32'hDEAD_BEEF, 3'd2);
        send(-1);
        expect_item(K_ERR, 0, 0, "R6");
        std_frame(1, 32'hC0DE_5EEC, 1'b0, 32'hDEAD_BEEF, 3'd2);
        send(-1);

        // R5: password mode but frame carries no password
        expect_item(K_ERR, 0, 0, "R5");
        std_frame(0, 0, 1'b0, 32'h1111_2222, 3'd1);
        send(-1);

        // R12: mode flips to off mid-frame, layout stays with password
        expect_item(K_PROG, 3'd6, {32'h2468_ACE0, 1'b1}, "R12");
        std_frame(1, 32'hC0DE_5EED, 1'b1, 32'h2468_ACE0, 3'd6);
        send(10);
        check(pwd_mode == 1'b0, "R12", "mode flipped", pwd_mode, 0);

        // R5: one extra bit without password
        expect_item(K_ERR, 0, 0, "R5");
        std_frame(0, 0, 1'b0, 32'h3333_4444, 3'd1);
        put(32'b1, 1);
        send(-1);

        // R3: stop opcode followed by junk bits
        expect_item(K_STOP, 0, 0, "R3");
        put(32'b11, 2);
        put(32'hFFFF_0000, 32);
        send(-1);

        // R2: illegal opcodes 01 and 00
        expect_item(K_ERR, 0, 0, "R2");
        put(32'b01, 2);
        put(32'h5A5A_5A5A, 32);
        put(32'h0, 4);
        send(-1);
        expect_item(K_ERR, 0, 0, "R2");
        put(32'b00, 2);
        send(-1);

        // R11: end-of-frame after one opcode bit
        expect_item(K_ERR, 0, 0, "R11");
        put(32'b1, 1);
        send(-1);

        // R10: end-of-frame with no bits gives nothing
        send(-1);
        check(sbq.size() == 0, "R10", "queue after empty frame", sbq.size(), 0);
        check(prog_addr == 3'd6, "R10", "fields after empty frame", prog_addr, 6);

        repeat (4) @(negedge clk);
        check(sbq.size() == 0, "R9", "outcomes still pending", sbq.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule